// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block selects one interrupt to hand to the processor core from a set of request sources. A per-source chain-select bit places each source on either the high-priority chain (level 1) or the low-priority chain (level 2). Changing that bit at run time lets software raise any source above every source left on the low chain.

Each chain has a global enable that comes from the core's status bits. The two enables act independently of each other. Inside a chain, the source with the lowest index wins. Between the chains, level 1 always beats level 2.

The arbiter only commits a decision on a cycle where the core reports that an instruction has completed, so an interrupt is never taken in the middle of an instruction. Once it commits, it raises a take flag. It holds the winning index and level until the core acknowledges.

Top module: `irq_two_level_arb`

## Requirements
- R1: After reset, `take` is 0, `win_idx` is 0 and `win_level` is 0.
- R2: A source takes part in arbitration only while both its `req` bit and its `src_en` bit are 1.
- R3: `chain_sel[i]`=1 puts source i on level 1 (reported as `win_level`=1). `chain_sel[i]`=0 puts it on level 2 (reported as `win_level`=0).
- R4: Within one chain, the eligible source with the lowest index wins.
- R5: Any eligible level 1 source wins over every level 2 source, whatever their indices.
- R6: `glb_en_hi`=0 removes only the level 1 chain from arbitration, and `glb_en_lo`=0 removes only the level 2 chain. Each enable has no effect on the other chain.
- R7: A decision is captured only on a clock edge where `insn_done`=1, `take`=0 and at least one source is eligible. `take` rises on that same edge. Eligible requests present without `insn_done` produce no take.
- R8: When `insn_done`=1 and no source is eligible, `take` stays 0.
- R9: While `take`=1, `win_idx` and `win_level` stay stable, and new requests or `insn_done` strobes are ignored. An edge with `ack`=1 clears `take`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | NSRC | Request line per source |
| src_en | input | NSRC | Local enable per source |
| chain_sel | input | NSRC | 1 = level 1 chain, 0 = level 2 chain |
| glb_en_hi | input | 1 | Global enable for level 1 |
| glb_en_lo | input | 1 | Global enable for level 2 |
| insn_done | input | 1 | Instruction-completion strobe |
| ack | input | 1 | Core acknowledge; clears the take state |
| take | output | 1 | Interrupt to be taken, held until ack |
| win_idx | output | $clog2(NSRC) | Index of the winning source |
| win_level | output | 1 | 1 = level 1 winner, 0 = level 2 winner |

## Verification
The assertions take for granted that `ack` is only raised while `take` is high, and that the inputs are steady around each clock edge. The bench drives every input on the falling edge. It asserts `ack` only in the cycle after a take has been observed, so both conditions hold. Requests may change freely while a take is pending. The checks require that such changes leave the held winner untouched.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic {LVL_TWO = 1'b0, LVL_ONE = 1'b1} irq_level_e;
endpackage

// File: rtl/irq_chain_pick.sv
module irq_chain_pick #(
  parameter int NSRC = 8,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] elig,
  output logic            any,
  output logic [IDXW-1:0] idx
);
  function automatic logic [IDXW-1:0] lowest_set(input logic [NSRC-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (v[i]) r = IDXW'(i);
    end
    return r;
  endfunction

  assign any = |elig;
  assign idx = lowest_set(elig);
endmodule

// File: rtl/irq_level_select.sv
module irq_level_select #(
  parameter int NSRC = 8,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            hi_any,
  input  logic [IDXW-1:0] hi_idx,
  input  logic            lo_any,
  input  logic [IDXW-1:0] lo_idx,
  output logic            any,
  output logic [IDXW-1:0] idx,
  output logic            level
);
  import irq_arb_pkg::*;
  assign any   = hi_any | lo_any;
  assign idx   = hi_any ? hi_idx : lo_idx;
  assign level = hi_any ? LVL_ONE : LVL_TWO;
endmodule

// File: rtl/irq_take_reg.sv
module irq_take_reg #(
  parameter int NSRC = 8,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_done,
  input  logic            ack,
  input  logic            cand_any,
  input  logic [IDXW-1:0] cand_idx,
  input  logic            cand_level,
  output logic            grant_ev,
  output logic            take,
  output logic [IDXW-1:0] win_idx,
  output logic            win_level
);
  assign grant_ev = !take && insn_done && cand_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take      <= 1'b0;
      win_idx   <= '0;
      win_level <= 1'b0;
    end else if (grant_ev) begin
      take      <= 1'b1;
      win_idx   <= cand_idx;
      win_level <= cand_level;
    end else if (take && ack) begin
      take      <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_two_level_arb.sv
module irq_two_level_arb #(
  parameter int NSRC = 8,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] chain_sel,
  input  logic            glb_en_hi,
  input  logic            glb_en_lo,
  input  logic            insn_done,
  input  logic            ack,
  output logic            take,
  output logic [IDXW-1:0] win_idx,
  output logic            win_level
);
  logic [NSRC-1:0] live;
  logic [NSRC-1:0] hi_vec, lo_vec;
  logic [1:0]      ch_any;
  logic [IDXW-1:0] ch_idx [2];
  logic            hi_any, lo_any, cand_any, cand_level, grant_ev;
  logic [IDXW-1:0] cand_idx;

  assign live   = req & src_en;
  assign hi_vec = live &  chain_sel & {NSRC{glb_en_hi}};
  assign lo_vec = live & ~chain_sel & {NSRC{glb_en_lo}};

  for (genvar c = 0; c < 2; c++) begin : g_chain
    irq_chain_pick #(.NSRC(NSRC)) u_pick (
      .elig (c == 1 ? hi_vec : lo_vec),
      .any  (ch_any[c]),
      .idx  (ch_idx[c])
    );
  end

  assign hi_any = ch_any[1];
  assign lo_any = ch_any[0];

  irq_level_select #(.NSRC(NSRC)) u_sel (
    .hi_any (hi_any),
    .hi_idx (ch_idx[1]),
    .lo_any (lo_any),
    .lo_idx (ch_idx[0]),
    .any    (cand_any),
    .idx    (cand_idx),
    .level  (cand_level)
  );

  irq_take_reg #(.NSRC(NSRC)) u_take (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_done  (insn_done),
    .ack        (ack),
    .cand_any   (cand_any),
    .cand_idx   (cand_idx),
    .cand_level (cand_level),
    .grant_ev   (grant_ev),
    .take       (take),
    .win_idx    (win_idx),
    .win_level  (win_level)
  );
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int NSRC = 8,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            insn_done,
  input logic            ack,
  input logic            take,
  input logic [IDXW-1:0] win_idx,
  input logic            win_level,
  input logic            hi_any,
  input logic            lo_any,
  input logic [NSRC-1:0] hi_vec,
  input logic [NSRC-1:0] lo_vec
);
  // R7
  rise_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take) |-> $past(insn_done));

  // R8
  idle_done_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && insn_done && !hi_any && !lo_any) |=> !take);

  // R9
  held_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ack) |=> (take && $stable(win_idx) && $stable(win_level)));

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ack) |=> !take);

  // R5
  level_one_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take) |-> (win_level == $past(hi_any)));

  // R4
  lowest_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take) |-> ((win_level ? $past(hi_vec) : $past(lo_vec))
                     & ((NSRC'(1) << win_idx) - NSRC'(1))) == '0);
endmodule

bind irq_two_level_arb irq_arb_chk #(.NSRC(NSRC)) u_chk (.*);

// File: tb/irq_two_level_arb_tb.sv
module irq_two_level_arb_tb;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, src_en = '0, chain_sel = '0;
  logic glb_en_hi = 1'b0, glb_en_lo = 1'b0, insn_done = 1'b0, ack = 1'b0;
  logic take;
  logic [IW-1:0] win_idx;
  logic win_level;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_two_level_arb #(.NSRC(N)) u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference: scan upward, first hit on level 1, else first hit on level 2.
  function automatic void model(input logic [N-1:0] r, input logic [N-1:0] e,
      input logic [N-1:0] s, input logic mh, input logic ml,
      output bit found, output int idx, output int lvl);
    found = 0; idx = 0; lvl = 0;
    for (int i = 0; i < N; i++)
      if (!found && r[i] && e[i] && s[i] && mh) begin found = 1; idx = i; lvl = 1; end
    for (int i = 0; i < N; i++)
      if (!found && r[i] && e[i] && !s[i] && ml) begin found = 1; idx = i; lvl = 0; end
  endfunction

  task automatic shot(input string tag, input logic [N-1:0] r, input logic [N-1:0] e,
      input logic [N-1:0] s, input logic mh, input logic ml);
    bit f; int ei, el;
    model(r, e, s, mh, ml, f, ei, el);
    @(negedge clk);
    req = r; src_en = e; chain_sel = s; glb_en_hi = mh; glb_en_lo = ml;
    insn_done = 1'b1;
    @(posedge clk); #1;
    chk({tag, " take"}, take, f);
    if (f) begin
      chk({tag, " idx"}, win_idx, ei);
      chk({tag, " level"}, win_level, el);
    end
    @(negedge clk);
    insn_done = 1'b0; ack = take;
    @(posedge clk); #1;
    chk({tag, " cleared"}, take, 0);
    @(negedge clk);
    ack = 1'b0; req = '0;
  endtask

  task automatic t_reset();
    chk("R1 take", take, 0);
    chk("R1 idx", win_idx, 0);
    chk("R1 level", win_level, 0);
  endtask

  task automatic t_enable();
    shot("R2 no local enable", 8'h10, 8'h00, 8'h10, 1, 1);
    shot("R2 enable masks low", 8'h11, 8'h10, 8'h00, 1, 1);
  endtask

  task automatic t_chain();
    shot("R3 to level1", 8'h20, 8'hFF, 8'h20, 1, 1);
    shot("R3 to level2", 8'h20, 8'hFF, 8'h00, 1, 1);
  endtask

  task automatic t_order();
    shot("R4 level2 order", 8'b1010_1000, 8'hFF, 8'h00, 1, 1);
    shot("R4 level1 order", 8'b1100_0110, 8'hFF, 8'hFF, 1, 1);
  endtask

  task automatic t_cross();
    shot("R5 hi beats lower idx", 8'b1000_0001, 8'hFF, 8'b1000_0000, 1, 1);
  endtask

  task automatic t_masks();
    shot("R6 hi masked", 8'b1000_0001, 8'hFF, 8'b1000_0000, 0, 1);
    shot("R6 lo masked", 8'b1000_0001, 8'hFF, 8'b1000_0000, 1, 0);
    shot("R6 lo masked only lo", 8'b0000_0001, 8'hFF, 8'h00, 1, 0);
  endtask

  task automatic t_no_done();
    @(negedge clk);
    req = 8'h04; src_en = 8'hFF; chain_sel = 8'h04; glb_en_hi = 1; glb_en_lo = 1;
    repeat (3) @(posedge clk);
    #1 chk("R7 no done no take", take, 0);
    @(negedge clk); insn_done = 1'b1;
    @(posedge clk); #1 chk("R7 take on done", take, 1);
    chk("R7 idx", win_idx, 2);
    @(negedge clk); insn_done = 1'b0; ack = 1'b1;
    @(negedge clk); ack = 1'b0; req = '0;
  endtask

  task automatic t_none();
    shot("R8 nothing eligible", 8'h00, 8'hFF, 8'hFF, 1, 1);
    shot("R8 all masked", 8'hFF, 8'hFF, 8'h0F, 0, 0);
  endtask

  task automatic t_hold();
    @(negedge clk);
    req = 8'h40; src_en = 8'hFF; chain_sel = 8'h00; glb_en_hi = 1; glb_en_lo = 1;
    insn_done = 1'b1;
    @(posedge clk); #1 chk("R9 grant", take, 1);
    @(negedge clk);
    req = 8'h01; chain_sel = 8'h01;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 still take", take, 1);
    chk("R9 idx held", win_idx, 6);
    chk("R9 level held", win_level, 0);
    @(negedge clk); insn_done = 1'b0; ack = 1'b1;
    @(posedge clk); #1 chk("R9 ack clears", take, 0);
    @(negedge clk); ack = 1'b0; insn_done = 1'b1;
    @(posedge clk); #1;
    chk("R9 new take", take, 1);
    chk("R9 new idx", win_idx, 0);
    chk("R9 new level", win_level, 1);
    @(negedge clk); insn_done = 1'b0; ack = 1'b1;
    @(negedge clk); ack = 1'b0; req = '0;
  endtask

  initial begin
    fork
      begin
        #3;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_enable();
        t_chain();
        t_order();
        t_cross();
        t_masks();
        t_no_done();
        t_none();
        t_hold();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule